// File: doc/BRIEF.md
# Two-Stage Memory and Bus Allocator

This block decides, once per clock cycle, which processors of a multiple-bus shared-memory system may start a memory transfer. Each processor presents a request valid bit and the index of the memory module it targets. Allocation then runs in two steps. First, every memory module picks at most one processor from the requesters aimed at it. Second, the module winners compete for a smaller pool of buses, and a fixed order that favours the lowest module index decides who gets one. A processor is granted only if it wins its module and also receives a bus. The granted processor is told which bus to use.

Each module accepts at most three requests in a cycle. The three lowest-numbered requesters of a module are accepted. Any other requester to that module is refused with a reject flag, so it can pick a new target. A processor that is accepted but then loses at its module, or that wins its module and gets no bus, sees neither grant nor reject and simply asks again the next cycle. The choice inside each module is made pluggable by a per-module start index. This index comes from outside, for example from a priority or fairness engine. Among the accepted requesters, the module picks the first one found at or after the start index, counting upward and wrapping around. No decision state is kept from one cycle to the next, so both stage flags of every processor are recomputed from scratch on each cycle.

Top module: `mbus_alloc`

## Requirements
- R1: Among the requesters accepted by module j, exactly one is selected when any are present: the one reached first when counting upward from `mod_first[j]` and wrapping from N-1 to 0.
- R2: Module winners receive buses in ascending module index. The k-th winning module, counting from k = 0, gets bus k, written as a binary number in `gnt_bus`. If there are more than B winners, the winners with higher module index get no bus.
- R3: `gnt[i]` is 1 only when processor i both wins its module and receives a bus.
- R4: A requesting processor that is neither granted nor rejected has both `gnt[i]` and `rej[i]` at 0, which means it must retry in the next cycle.
- R5: At most three requests per module are accepted in a cycle, namely those from the lowest processor indices. Every further requester to that module has `rej[i]` = 1 and is never granted.
- R6: No allocation state carries across cycles. A cycle with no valid request gives all-zero `gnt` and `rej`.
- R7: The results for the inputs sampled at a rising clock edge appear on the outputs right after that edge. While `rst_n` is low, all outputs are 0.
- R8: The `gnt_bus` field of a processor that is not granted is 0. Field i occupies bits [i*LGB +: LGB].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_vld | input | N | Per-processor request valid |
| req_mod | input | N*LGM | Per-processor target module index, field i at [i*LGM +: LGM] |
| mod_first | input | M*LGN | Per-module start index for the selection search, field j at [j*LGN +: LGN] |
| gnt | output | N | Per-processor grant (won module and bus) |
| gnt_bus | output | N*LGB | Per-processor assigned bus index, binary, 0 when not granted |
| rej | output | N | Per-processor over-limit reject |

## Verification
The assertions check four things on every cycle. The number of grants never exceeds B. No two granted processors share a bus. A grant and a reject never appear together, and a grant always follows a valid request. Every processor without a grant shows a zero bus field. Some behaviour can only be shown by the bench scenarios, which compare the outputs against an arithmetic model. These are the exact wrap-around choice inside a module, which three requesters are accepted under overload, and which modules lose out when there are more winners than buses.

// File: rtl/mbus_alloc.sv
module mbus_alloc #(
  parameter int N      = 8,
  parameter int M      = 8,
  parameter int B      = 4,
  parameter int MAXREQ = 3,
  localparam int LGN = (N > 1) ? $clog2(N) : 1,
  localparam int LGM = (M > 1) ? $clog2(M) : 1,
  localparam int LGB = (B > 1) ? $clog2(B) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]     req_vld,
  input  logic [N*LGM-1:0] req_mod,
  input  logic [M*LGN-1:0] mod_first,
  output logic [N-1:0]     gnt,
  output logic [N*LGB-1:0] gnt_bus,
  output logic [N-1:0]     rej
);

  logic [LGM-1:0] tgt   [N];
  logic [LGN-1:0] first [M];

  for (genvar i = 0; i < N; i++) begin : g_tgt
    assign tgt[i] = req_mod[i*LGM +: LGM];
  end
  for (genvar j = 0; j < M; j++) begin : g_first
    assign first[j] = mod_first[j*LGN +: LGN];
  end

  logic [N-1:0]   acc, rj_d, s1, s2;
  logic [LGB-1:0] bus_d [N];
  logic [LGN-1:0] winp  [M];
  logic [M-1:0]   mwin;

  // acceptance limit per module, lowest processor index first
  always_comb begin
    int cnt [M];
    for (int j = 0; j < M; j++) cnt[j] = 0;
    acc  = '0;
    rj_d = '0;
    for (int i = 0; i < N; i++) begin
      if (req_vld[i]) begin
        if (cnt[tgt[i]] < MAXREQ) begin
          acc[i] = 1'b1;
          cnt[tgt[i]] = cnt[tgt[i]] + 1;
        end else begin
          rj_d[i] = 1'b1;
        end
      end
    end
  end

  // stage 1: one winner per module, cyclic search from the start index
  always_comb begin
    logic [LGN-1:0] p;
    s1   = '0;
    mwin = '0;
    for (int j = 0; j < M; j++) begin
      winp[j] = '0;
      for (int off = 0; off < N; off++) begin
        p = first[j] + LGN'(off);
        if (!mwin[j] && acc[p] && tgt[p] == LGM'(j)) begin
          mwin[j] = 1'b1;
          winp[j] = p;
          s1[p]   = 1'b1;
        end
      end
    end
  end

  // stage 2: fixed priority, lowest module index takes the next free bus
  always_comb begin
    int nb;
    nb = 0;
    s2 = '0;
    for (int i = 0; i < N; i++) bus_d[i] = '0;
    for (int j = 0; j < M; j++) begin
      if (mwin[j] && nb < B) begin
        s2[winp[j]]    = 1'b1;
        bus_d[winp[j]] = LGB'(nb);
        nb = nb + 1;
      end
    end
  end

  logic [N-1:0]   gnt_q, rej_q;
  logic [LGB-1:0] bus_q [N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_q <= '0;
      rej_q <= '0;
      for (int i = 0; i < N; i++) bus_q[i] <= '0;
    end else begin
      gnt_q <= s1 & s2;
      rej_q <= rj_d;
      for (int i = 0; i < N; i++) bus_q[i] <= (s1[i] && s2[i]) ? bus_d[i] : '0;
    end
  end

  assign gnt = gnt_q;
  assign rej = rej_q;
  for (genvar i = 0; i < N; i++) begin : g_bus
    assign gnt_bus[i*LGB +: LGB] = bus_q[i];
  end

  p_bus_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(gnt_q) <= B);

  p_no_gnt_rej_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_q & rej_q) == '0);

  p_gnt_has_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_q & ~$past(req_vld)) == '0);

  for (genvar i = 0; i < N; i++) begin : g_chk
    p_idle_bus_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !gnt_q[i] |-> bus_q[i] == '0);
    for (genvar k = i + 1; k < N; k++) begin : g_pair
      p_bus_unique_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_q[i] && gnt_q[k]) |-> bus_q[i] != bus_q[k]);
    end
  end

endmodule

// File: tb/test_mbus_alloc.sv
`timescale 1ns/1ps
module test_mbus_alloc;
  localparam int N = 8, M = 8, B = 4;
  localparam int LGN = 3, LGM = 3, LGB = 2;

  logic clk = 0, rst_n = 0;
  logic [N-1:0]     req_vld = '0;
  logic [N*LGM-1:0] req_mod = '0;
  logic [M*LGN-1:0] mod_first = '0;
  logic [N-1:0]     gnt, rej;
  logic [N*LGB-1:0] gnt_bus;

  int nchk = 0, nfail = 0;
  bit done = 0;
  logic [31:0] lfsr = 32'h1ACE_5EED;

  always #2.5 clk = ~clk;

  mbus_alloc i_mbus_alloc (.clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_mod(req_mod),
    .mod_first(mod_first), .gnt(gnt), .gnt_bus(gnt_bus), .rej(rej));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // model: per module, list requesters ascending; first three accepted;
  // winner has the smallest cyclic distance from the start index;
  // winners ranked by module index get buses 0..B-1
  task automatic model(output logic [N-1:0] eg, output logic [N*LGB-1:0] eb,
                       output logic [N-1:0] er);
    int rank;
    eg = '0; eb = '0; er = '0; rank = 0;
    for (int j = 0; j < M; j++) begin
      int n, bestd, w, f;
      n = 0; bestd = N; w = 0;
      f = int'(mod_first[j*LGN +: LGN]);
      for (int i = 0; i < N; i++) begin
        if (req_vld[i] && int'(req_mod[i*LGM +: LGM]) == j) begin
          if (n < 3) begin
            n++;
            if ((i - f + N) % N < bestd) begin bestd = (i - f + N) % N; w = i; end
          end else er[i] = 1'b1;
        end
      end
      if (bestd < N) begin
        if (rank < B) begin
          eg[w] = 1'b1;
          eb[w*LGB +: LGB] = LGB'(rank);
        end
        rank++;
      end
    end
  endtask

  task automatic apply();
    logic [N-1:0] eg, er;
    logic [N*LGB-1:0] eb;
    model(eg, eb, er);
    @(posedge clk);
    @(negedge clk);
    check("R3 grant", 32'(gnt), 32'(eg));
    check("R2 bus", 32'(gnt_bus), 32'(eb));
    check("R5 reject", 32'(rej), 32'(er));
    check("R4 retry", 32'(req_vld & ~gnt & ~rej), 32'(req_vld & ~eg & ~er));
  endtask

  task automatic step_lfsr();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R7 reset gnt", 32'(gnt), 0);
    check("R7 reset rej", 32'(rej), 0);
    check("R7 reset bus", 32'(gnt_bus), 0);
    rst_n = 1;
    @(negedge clk);

    // R6: no requests, nothing granted
    req_vld = '0;
    apply();
    check("R6 idle", 32'({gnt, rej}), 0);

    // R5: all processors to module 2
    for (int i = 0; i < N; i++) req_mod[i*LGM +: LGM] = 3'd2;
    req_vld = '1;
    mod_first = '0;
    apply();
    check("R5 cap rej", 32'(rej), 32'h0F8);
    mod_first[2*LGN +: LGN] = 3'd1;
    apply();
    check("R1 start 1", 32'(gnt), 32'h002);
    mod_first[2*LGN +: LGN] = 3'd5;
    apply();
    check("R1 wrap", 32'(gnt), 32'h001);

    // R2: every module has one requester, processor i -> module 7-i
    for (int i = 0; i < N; i++) req_mod[i*LGM +: LGM] = 3'(7 - i);
    mod_first = '0;
    apply();
    check("R2 low modules win", 32'(gnt), 32'h0F0);
    check("R2 bus of proc 7", 32'(gnt_bus[7*LGB +: LGB]), 0);
    check("R8 idle bus", 32'(gnt_bus[0 +: 4*LGB]), 0);

    // R6: flags do not linger after requests drop
    req_vld = '0;
    apply();
    check("R6 cleared", 32'(gnt), 0);

    // sweep: random targets, dense and sparse
    for (int v = 0; v < 3000; v++) begin
      step_lfsr();
      req_vld = lfsr[7:0] | ((v % 3 == 0) ? 8'hFF : 8'h00);
      step_lfsr();
      req_mod = 24'(lfsr[23:0]);
      if (v % 2 == 0)
        for (int i = 0; i < N; i++) req_mod[i*LGM + 2] = 1'b0;
      step_lfsr();
      mod_first = 24'(lfsr[23:0]);
      apply();
      for (int i = 0; i < N; i++)
        if (!gnt[i]) check("R8 bus zero", 32'(gnt_bus[i*LGB +: LGB]), 0);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule